// File: doc/BRIEF.md
# Rotating Bank Refresh Scheduler

This controller keeps data alive in a store made of banks that each hold their contents for only a limited number of clock periods. It keeps `BANKS` logical banks in `BANKS+1` physical banks, so one physical bank is always empty. A free-running interval timer fires once every `PERIOD` cycles. Each time it fires, the bank that follows the empty one (wrapping from the highest index to zero) is copied word by word into the empty bank. The source bank is then wiped and becomes the new empty bank. After `BANKS+1` moves the empty slot has visited every physical bank, so every stored word is renewed once per full rotation.

Users see stable logical banks. A logical-to-physical map is rewritten when each move completes. The request port is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While it waits, the requester must hold the request fields stable. `req_ready` drops only while a move is running and the request targets the logical bank whose physical bank is the current move source. Requests to the other logical banks proceed during a move. The read response has no back-pressure: `rsp_valid` pulses for one cycle and the requester must take `rsp_data` in that cycle. `req_bank` must be below `BANKS`. `PERIOD` must exceed `DEPTH+1`.

Top module: `rotating_refresh_ctrl`

## Requirements
- R1: After reset, `empty_bank` equals `BANKS`, `busy` is low, and `req_ready` is high. Every word of every logical bank reads as zero. Logical bank j is held in physical bank j.
- R2: The interval timer runs without pause, including during moves. A move begins every `PERIOD` cycles, so `busy` is first high after exactly `PERIOD` clock edges following reset release, and again every `PERIOD` edges after that.
- R3: Each move keeps `busy` high for exactly `DEPTH+1` cycles. The first `DEPTH` cycles copy one word per cycle from the source to the empty bank, in address order. The last cycle wipes the whole source bank to zero.
- R4: The move source is the physical bank numbered one above `empty_bank`, wrapping from `BANKS` to 0. When a move ends, `empty_bank` takes the source index. Between moves, `empty_bank` does not change.
- R5: A read of logical bank b at address a returns the last value written there, however many moves have taken place since.
- R6: While `busy` is high, `req_ready` is low for requests whose logical bank sits in the move source bank. At all other times, and for all other logical banks, `req_ready` is high.
- R7: A write (`req_write`=1) is accepted on a valid/ready edge and produces no response.
- R8: An accepted read (`req_write`=0) raises `rsp_valid` for exactly one cycle, on the next clock edge, with the word in `rsp_data`. In every other cycle `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | clog2(BANKS) | Logical bank index |
| req_addr | input | clog2(DEPTH) | Word address within the bank |
| req_wdata | input | WIDTH | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | WIDTH | Read data |
| busy | output | 1 | A move (copy or wipe) is in progress |
| empty_bank | output | clog2(BANKS+1) | Physical index of the empty bank |

## Verification
After e clock edges from reset release, `busy` is predicted high when e is at least `PERIOD` and e mod `PERIOD` is at most `DEPTH`. The number of completed moves, and from it `empty_bank` and the map, follow from the same count. `req_ready` is combinational, so it is checked in the same cycle the request is driven. Read data is due one edge after acceptance and is checked in the next sampled cycle against a logical-bank model captured at acceptance. All inputs change on the falling edge and all outputs are sampled one nanosecond later, away from the active edge.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COPY  = 2'd1,
    PH_WIPE  = 2'd2
  } move_phase_t;
endpackage

// File: rtl/rbr_interval_timer.sv
module rbr_interval_timer #(
  parameter int PERIOD = 40,
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [TW-1:0] cnt_q;

  assign tick = (cnt_q == TW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rbr_move_seq.sv
module rbr_move_seq
  import rbr_pkg::*;
#(
  parameter int NPHYS = 4,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(NPHYS),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic          busy,
  output logic          copy_en,
  output logic [AW-1:0] copy_idx,
  output logic          wipe_en,
  output logic [PW-1:0] src,
  output logic [PW-1:0] dst,
  output logic          done
);
  move_phase_t   phase_q;
  logic [AW-1:0] idx_q;
  logic [PW-1:0] empty_q;

  assign src      = (empty_q == PW'(NPHYS - 1)) ? '0 : empty_q + 1'b1;
  assign dst      = empty_q;
  assign busy     = (phase_q != PH_IDLE);
  assign copy_en  = (phase_q == PH_COPY);
  assign wipe_en  = (phase_q == PH_WIPE);
  assign done     = wipe_en;
  assign copy_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      empty_q <= PW'(NPHYS - 1);
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (tick) begin
            phase_q <= PH_COPY;
            idx_q   <= '0;
          end
        end
        PH_COPY: begin
          if (idx_q == AW'(DEPTH - 1)) phase_q <= PH_WIPE;
          else                         idx_q   <= idx_q + 1'b1;
        end
        PH_WIPE: begin
          phase_q <= PH_IDLE;
          empty_q <= src;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbr_bank_map.sv
module rbr_bank_map #(
  parameter int NLOG  = 3,
  localparam int NPHYS = NLOG + 1,
  localparam int PW = $clog2(NPHYS),
  localparam int LW = (NLOG > 1) ? $clog2(NLOG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [PW-1:0] src,
  input  logic [PW-1:0] dst,
  input  logic [LW-1:0] lookup,
  output logic [PW-1:0] phys
);
  logic [PW-1:0] map_q [NLOG];

  assign phys = map_q[lookup];

  for (genvar j = 0; j < NLOG; j++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          map_q[j] <= PW'(j);
      else if (done && (map_q[j] == src))  map_q[j] <= dst;
    end
  end
endmodule

// File: rtl/rbr_bank.sv
module rbr_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b
);
  logic [WIDTH-1:0] word_q [DEPTH];

  assign rd_data_a = word_q[rd_addr_a];
  assign rd_data_b = word_q[rd_addr_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else if (wipe) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else if (wr_en) begin
      word_q[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/rbr_bank_array.sv
module rbr_bank_array #(
  parameter int NPHYS = 4,
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(NPHYS),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             copy_en,
  input  logic [AW-1:0]    copy_idx,
  input  logic             wipe_en,
  input  logic [PW-1:0]    src,
  input  logic [PW-1:0]    dst,
  input  logic             uwr_en,
  input  logic [PW-1:0]    ubank,
  input  logic [AW-1:0]    uaddr,
  input  logic [WIDTH-1:0] uwdata,
  output logic [WIDTH-1:0] urdata
);
  logic [NPHYS-1:0][WIDTH-1:0] rd_a_all;
  logic [NPHYS-1:0][WIDTH-1:0] rd_b_all;
  logic [WIDTH-1:0]            copy_word;

  assign copy_word = rd_a_all[src];
  assign urdata    = rd_b_all[ubank];

  for (genvar p = 0; p < NPHYS; p++) begin : g_bank
    logic             cp_hit;
    logic             us_hit;
    logic [AW-1:0]    w_addr;
    logic [WIDTH-1:0] w_data;

    assign cp_hit = copy_en && (dst == PW'(p));
    assign us_hit = uwr_en && (ubank == PW'(p));
    assign w_addr = cp_hit ? copy_idx  : uaddr;
    assign w_data = cp_hit ? copy_word : uwdata;

    rbr_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wipe      (wipe_en && (src == PW'(p))),
      .wr_en     (cp_hit || us_hit),
      .wr_addr   (w_addr),
      .wr_data   (w_data),
      .rd_addr_a (copy_idx),
      .rd_data_a (rd_a_all[p]),
      .rd_addr_b (uaddr),
      .rd_data_b (rd_b_all[p])
    );
  end
endmodule

// File: rtl/rotating_refresh_ctrl.sv
module rotating_refresh_ctrl #(
  parameter int BANKS  = 3,
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 16,
  parameter int PERIOD = 40,
  localparam int NPHYS = BANKS + 1,
  localparam int PW = $clog2(NPHYS),
  localparam int LW = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [LW-1:0]    req_bank,
  input  logic [AW-1:0]    req_addr,
  input  logic [WIDTH-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_data,
  output logic             busy,
  output logic [PW-1:0]    empty_bank
);
  logic          tick;
  logic          copy_en;
  logic          wipe_en;
  logic          move_done;
  logic [AW-1:0] copy_idx;
  logic [PW-1:0] src_bank;
  logic [PW-1:0] dst_bank;
  logic [PW-1:0] req_phys;
  logic [WIDTH-1:0] rd_word;
  logic          accept;

  rbr_interval_timer #(.PERIOD(PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  rbr_move_seq #(.NPHYS(NPHYS), .DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .busy     (busy),
    .copy_en  (copy_en),
    .copy_idx (copy_idx),
    .wipe_en  (wipe_en),
    .src      (src_bank),
    .dst      (dst_bank),
    .done     (move_done)
  );

  rbr_bank_map #(.NLOG(BANKS)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (move_done),
    .src    (src_bank),
    .dst    (dst_bank),
    .lookup (req_bank),
    .phys   (req_phys)
  );

  assign empty_bank = dst_bank;
  assign req_ready  = !(busy && (req_phys == src_bank));
  assign accept     = req_valid && req_ready;

  rbr_bank_array #(.NPHYS(NPHYS), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .copy_en  (copy_en),
    .copy_idx (copy_idx),
    .wipe_en  (wipe_en),
    .src      (src_bank),
    .dst      (dst_bank),
    .uwr_en   (accept && req_write),
    .ubank    (req_phys),
    .uaddr    (req_addr),
    .uwdata   (req_wdata),
    .urdata   (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) rsp_data <= rd_word;
    end
  end
endmodule

// File: rtl/rotating_refresh_ctrl_chk.sv
module rotating_refresh_ctrl_chk #(
  parameter int NPHYS = 4,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(NPHYS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [PW-1:0] req_phys,
  input logic [PW-1:0] src_bank,
  input logic [PW-1:0] empty_bank,
  input logic          rsp_valid
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));

  assert_tick_starts_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy) |=> busy);

  assert_move_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == DEPTH + 1));

  assert_empty_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (empty_bank == (($past(empty_bank) == PW'(NPHYS - 1)) ?
                                    PW'(0) : PW'($past(empty_bank) + 1'b1))));

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$fell(busy)) |-> $stable(empty_bank));

  assert_no_source_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && busy) |-> (req_phys != src_bank));

  assert_rsp_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  assert_read_gets_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

bind rotating_refresh_ctrl rotating_refresh_ctrl_chk #(.NPHYS(NPHYS), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .busy       (busy),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_phys   (req_phys),
  .src_bank   (src_bank),
  .empty_bank (empty_bank),
  .rsp_valid  (rsp_valid)
);

// File: tb/test_rotating_refresh_ctrl.sv
`timescale 1ns/1ps
module test_rotating_refresh_ctrl;
  localparam int K  = 3;
  localparam int D  = 8;
  localparam int W  = 16;
  localparam int N  = 40;
  localparam int NP = K + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_bank = '0;
  logic [2:0]    req_addr = '0;
  logic [W-1:0]  req_wdata = '0;
  logic          rsp_valid;
  logic [W-1:0]  rsp_data;
  logic          busy;
  logic [1:0]    empty_bank;

  int            n_tests = 0;
  int            n_fail  = 0;
  int            edges   = 0;
  int            stalls  = 0;
  logic [W-1:0]  model [K][D];
  bit            rd_pend = 0;
  logic [W-1:0]  rd_exp  = '0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  rotating_refresh_ctrl #(.BANKS(K), .DEPTH(D), .WIDTH(W), .PERIOD(N)) i_rotating_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .empty_bank(empty_bank)
  );

  function automatic bit f_busy(int e);
    return (e >= N) && ((e % N) <= D);
  endfunction

  function automatic int f_moves(int e);
    return (e >= N + D + 1) ? ((e - N - D - 1) / N + 1) : 0;
  endfunction

  function automatic int f_empty(int r);
    return (K + r) % NP;
  endfunction

  function automatic int f_phys(int r, int j);
    int m [K];
    int emp = K;
    for (int i = 0; i < K; i++) m[i] = i;
    for (int s = 0; s < r; s++) begin
      int sb = (emp + 1) % NP;
      for (int i = 0; i < K; i++) if (m[i] == sb) m[i] = emp;
      emp = sb;
    end
    return m[j];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit wr, int bank, int addr, int data);
    bit eb, er;
    int r;
    @(negedge clk);
    req_valid = v; req_write = wr; req_bank = 2'(bank);
    req_addr = 3'(addr); req_wdata = W'(data);
    #1;
    eb = f_busy(edges);
    r  = f_moves(edges);
    er = !(eb && f_phys(r, bank) == (f_empty(r) + 1) % NP);
    check(busy == eb, "R2", "busy", int'(busy), int'(eb));
    if (edges == N) check(busy == 1'b1, "R3", "move start", int'(busy), 1);
    if (edges == N + D) check(busy == 1'b1, "R3", "wipe cycle", int'(busy), 1);
    if (edges == N + D + 1) check(busy == 1'b0, "R3", "move end", int'(busy), 0);
    check(int'(empty_bank) == f_empty(r), "R4", "empty_bank", int'(empty_bank), f_empty(r));
    check(req_ready == er, "R6", "req_ready", int'(req_ready), int'(er));
    if (!er) stalls++;
    if (rd_pend) begin
      check(rsp_valid == 1'b1, "R8", "rsp_valid", int'(rsp_valid), 1);
      check(rsp_data == rd_exp, "R5", "rsp_data", int'(rsp_data), int'(rd_exp));
    end else begin
      check(rsp_valid == 1'b0, "R7", "no response", int'(rsp_valid), 0);
    end
    rd_pend = 0;
    if (v && req_ready) begin
      if (wr) model[bank][addr] = W'(data);
      else begin
        rd_pend = 1;
        rd_exp  = model[bank][addr];
      end
    end
  endtask

  initial begin
    #150000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    for (int b = 0; b < K; b++) for (int a = 0; a < D; a++) model[b][a] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(int'(empty_bank) == K, "R1", "empty in reset", int'(empty_bank), K);
    check(rsp_valid == 1'b0, "R1", "rsp in reset", int'(rsp_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: all words read zero before any write
    for (int b = 0; b < K; b++) for (int a = 0; a < D; a++) step(1, 0, b, a, 0);
    // R5/R7: fill with distinct patterns
    for (int b = 0; b < K; b++)
      for (int a = 0; a < D; a++) begin
        int tries = 0;
        do begin
          step(1, 1, b, a, 16'hA000 + b * 16 + a);
          tries++;
        end while (!req_ready && tries < 20);
      end
    // random traffic across many rotations
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      step(sel < 6, sel < 2, $urandom_range(0, K - 1), $urandom_range(0, D - 1),
           $urandom_range(0, 16'hFFFF));
    end
    // R5: final sweep of every word
    for (int b = 0; b < K; b++)
      for (int a = 0; a < D; a++) begin
        step(1, 0, b, a, 0);
        while (!req_ready) step(1, 0, b, a, 0);
      end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(stalls > 0, "R6", "stalls seen", stalls, 1);
    check(f_moves(edges) >= NP, "R4", "full rotation reached", f_moves(edges), NP);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule